// File: doc/BRIEF.md
# Serial interrupt line agent

This block is the peripheral end of a shared serial interrupt wire. The wire is open-drain: it is pulled high and any agent may pull it low. The block reports a set of active-low local interrupt/data inputs over that wire. A host opens each cycle with a Start Frame, which is a low pulse. Then a train of three-clock slots follows, and a Stop Frame closes the cycle. The agent puts the level of each of its inputs into the slot given by a per-input slot map.

The agent tracks the wire through a small frame machine. It counts slots from the clock on which the Start Frame pulse goes back high. It measures the low width of every Stop Frame, and that width picks the mode for the next cycle. In Continuous mode the agent only answers cycles that the host opens. In Quiet mode the agent may also open a cycle. It does so when one of its inputs changed and no cycle has yet carried that change. To open the cycle, it pulls the wire low for one clock and leaves the rest of the pulse to the host.

The wire is resolved outside the block. `line_in` is the resolved level. When `line_oe` is high, the agent drives `line_dout` onto the wire.

Top module: `sirq_agent`

## Requirements
- R1: While reset is held and just after it, `line_oe` is 0 and the agent is in Continuous mode.
- R2: The clock on which `line_in` first reads high after a Start Frame low is clock 0. Slot k (k = 0 .. NUM_FRAMES-1) has its sample clock at clock 3k+2. On that clock the agent drives the wire low (`line_oe`=1, `line_dout`=0) if any input mapped to slot k was low one clock earlier. Otherwise it leaves the wire released.
- R3: On clock 3k+3 the agent drives the wire high (`line_oe`=1, `line_dout`=1) only if it drove slot k low on the clock before. It never drives high on any other clock.
- R4: On clock 3k+4, the turn-around clock, the agent never drives.
- R5: Slots are driven the same way whether the host or this agent opened the cycle.
- R6: In Quiet mode, an input can change after its slot was sampled, or while no cycle is running. The agent then opens a cycle once the wire is idle: it drives the wire low for exactly one clock and releases it on the next clock.
- R7: An input change that is visible on or before its slot's sample clock is carried by that cycle and causes no self-started cycle.
- R8: In Continuous mode the agent never drives the wire outside sample and recovery clocks, whatever its inputs do.
- R9: A Stop Frame low width of 2 clocks selects Quiet mode, and a width of 3 selects Continuous mode. Any other width keeps the current mode. The mode changes only when a Stop Frame ends.
- R10: An input whose slot map value is NUM_FRAMES or more is ignored. It is never driven onto the wire and never causes a self-started cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Local active-low interrupt/data inputs |
| slot_map | input | NUM_IRQ*SLOT_W | Slot index for each input; input j uses bits [j*SLOT_W +: SLOT_W] |
| line_in | input | 1 | Resolved level of the shared wire |
| line_oe | output | 1 | Agent drives the wire when high |
| line_dout | output | 1 | Level driven when `line_oe` is high |

## Verification
The bench maps one input to slot 1, one to slot 5, one to the last slot and one to an out-of-range index. It then checks the sample, recovery and turn-around clock of every slot in each cycle. A slot count that is off by one clock would show up as a level in the neighbouring slot. A missing recovery drive or a late release would be caught on the recovery or turn-around clock.

Inputs are changed just after their slot has passed and also well before it. A design that confused the two would either lose an interrupt, because it never opens a cycle, or open a spurious one. Stop widths of 2, 3 and 5 are exercised. A wrong width decode or a self-start in Continuous mode would show up as a wire drive while the line is idle. The out-of-range input is toggled and must never wake the wire.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OWN,
    ST_START,
    ST_LEAD,
    ST_DATA,
    ST_STOPW,
    ST_STOPL
  } sirq_st_e;

  typedef enum logic [1:0] {
    PH_SMP,
    PH_REC,
    PH_TA
  } sirq_ph_e;

  typedef enum logic {
    MODE_CONT,
    MODE_QUIET
  } sirq_mode_e;

  localparam int unsigned QUIET_STOP_W = 2;
  localparam int unsigned CONT_STOP_W  = 3;

  // Mode chosen by a finished Stop Frame of low width w.
  function automatic sirq_mode_e next_mode(input int unsigned w, input sirq_mode_e cur);
    if (w == QUIET_STOP_W) return MODE_QUIET;
    if (w == CONT_STOP_W)  return MODE_CONT;
    return cur;
  endfunction

  // True when a slot index lies inside the configured frame count.
  function automatic logic slot_ok(input int unsigned slot, input int unsigned nframes);
    return slot < nframes;
  endfunction

endpackage

// File: rtl/sirq_change_track.sv
module sirq_change_track #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] valid_vec,
  input  logic [NUM_IRQ-1:0] clr_vec,
  output logic [NUM_IRQ-1:0] irq_lvl,
  output logic [NUM_IRQ-1:0] pend_vec
);

  logic [NUM_IRQ-1:0] irq_prev;
  logic [NUM_IRQ-1:0] chg_vec;

  assign chg_vec = irq_lvl ^ irq_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lvl  <= '1;
      irq_prev <= '1;
      pend_vec <= '0;
    end else begin
      irq_lvl  <= irq_in;
      irq_prev <= irq_lvl;
      pend_vec <= (pend_vec | (chg_vec & valid_vec)) & ~clr_vec;
    end
  end

endmodule

// File: rtl/sirq_slot_drive.sv
module sirq_slot_drive #(
  parameter int NUM_IRQ    = 4,
  parameter int NUM_FRAMES = 21,
  parameter int SLOT_W     = 6
) (
  input  logic [NUM_IRQ-1:0]        irq_lvl,
  input  logic [NUM_IRQ*SLOT_W-1:0] slot_map,
  input  logic [SLOT_W-1:0]         cur_slot,
  output logic [NUM_IRQ-1:0]        valid_vec,
  output logic [NUM_IRQ-1:0]        hit_vec,
  output logic                      want_low
);

  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_in
    logic [SLOT_W-1:0] map_j;
    assign map_j        = slot_map[j*SLOT_W +: SLOT_W];
    assign valid_vec[j] = sirq_pkg::slot_ok(32'(map_j), NUM_FRAMES);
    assign hit_vec[j]   = valid_vec[j] && (map_j == cur_slot);
  end

  assign want_low = |(hit_vec & ~irq_lvl);

endmodule

// File: rtl/sirq_frame_fsm.sv
module sirq_frame_fsm
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter int SLOT_W     = 6,
  parameter int WCNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              start_req,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              smp_phase,
  output logic              rec_phase,
  output logic              ta_phase,
  output logic              own_start,
  output logic              stop_end,
  output logic              mode_quiet
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_FRAMES - 1);

  sirq_st_e          st;
  sirq_ph_e          ph;
  sirq_mode_e        mode;
  logic [WCNT_W-1:0] wcnt;

  assign smp_phase  = (st == ST_DATA) && (ph == PH_SMP);
  assign rec_phase  = (st == ST_DATA) && (ph == PH_REC);
  assign ta_phase   = (st == ST_DATA) && (ph == PH_TA);
  assign own_start  = (st == ST_OWN);
  assign stop_end   = (st == ST_STOPL) && line_in;
  assign mode_quiet = (mode == MODE_QUIET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_SMP;
      mode     <= MODE_CONT;
      cur_slot <= '0;
      wcnt     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!line_in) st <= ST_START;
          else if (mode == MODE_QUIET && start_req) st <= ST_OWN;
        end
        ST_OWN:   st <= ST_START;
        ST_START: if (line_in) st <= ST_LEAD;
        ST_LEAD: begin
          st       <= ST_DATA;
          ph       <= PH_SMP;
          cur_slot <= '0;
        end
        ST_DATA: begin
          case (ph)
            PH_SMP: ph <= PH_REC;
            PH_REC: ph <= PH_TA;
            default: begin
              if (cur_slot == LAST_SLOT) begin
                st <= ST_STOPW;
              end else begin
                cur_slot <= cur_slot + 1'b1;
                ph       <= PH_SMP;
              end
            end
          endcase
        end
        ST_STOPW: begin
          if (!line_in) begin
            st   <= ST_STOPL;
            wcnt <= WCNT_W'(1);
          end
        end
        ST_STOPL: begin
          if (!line_in) begin
            if (wcnt != '1) wcnt <= wcnt + 1'b1;
          end else begin
            mode <= next_mode(32'(wcnt), mode);
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent #(
  parameter int NUM_IRQ    = 4,
  parameter int NUM_FRAMES = 21,
  localparam int SLOT_W    = $clog2(NUM_FRAMES) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_in,
  input  logic [NUM_IRQ*SLOT_W-1:0] slot_map,
  input  logic                      line_in,
  output logic                      line_oe,
  output logic                      line_dout
);

  localparam int WCNT_W = 3;

  logic [SLOT_W-1:0]  cur_slot;
  logic               smp_phase, rec_phase, ta_phase;
  logic               own_start, stop_end, mode_quiet;
  logic               want_low, drove_q;
  logic [NUM_IRQ-1:0] irq_lvl, valid_vec, hit_vec, pend_vec, clr_vec;

  assign clr_vec = hit_vec & {NUM_IRQ{smp_phase}};

  sirq_change_track #(.NUM_IRQ(NUM_IRQ)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .valid_vec(valid_vec),
    .clr_vec  (clr_vec),
    .irq_lvl  (irq_lvl),
    .pend_vec (pend_vec)
  );

  sirq_slot_drive #(
    .NUM_IRQ   (NUM_IRQ),
    .NUM_FRAMES(NUM_FRAMES),
    .SLOT_W    (SLOT_W)
  ) u_drive (
    .irq_lvl  (irq_lvl),
    .slot_map (slot_map),
    .cur_slot (cur_slot),
    .valid_vec(valid_vec),
    .hit_vec  (hit_vec),
    .want_low (want_low)
  );

  sirq_frame_fsm #(
    .NUM_FRAMES(NUM_FRAMES),
    .SLOT_W    (SLOT_W),
    .WCNT_W    (WCNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .start_req (|pend_vec),
    .cur_slot  (cur_slot),
    .smp_phase (smp_phase),
    .rec_phase (rec_phase),
    .ta_phase  (ta_phase),
    .own_start (own_start),
    .stop_end  (stop_end),
    .mode_quiet(mode_quiet)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) drove_q <= 1'b0;
    else        drove_q <= smp_phase & want_low;
  end

  assign line_oe   = own_start | (smp_phase & want_low) | (rec_phase & drove_q);
  assign line_dout = rec_phase & drove_q;

endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk (
  input logic clk,
  input logic rst_n,
  input logic line_oe,
  input logic line_dout,
  input logic smp_phase,
  input logic rec_phase,
  input logic ta_phase,
  input logic own_start,
  input logic stop_end,
  input logic mode_quiet
);

  // R4
  ta_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta_phase |-> !line_oe);

  // R3
  rec_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_phase && line_oe) |-> $past(smp_phase && line_oe && !line_dout));

  // R3
  high_only_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_dout) |-> rec_phase);

  // R2
  low_only_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && !line_dout) |-> (smp_phase || own_start));

  // R6
  own_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_start |=> !own_start);

  // R8
  cont_passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_quiet |-> !own_start);

  // R9
  mode_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_end |=> $stable(mode_quiet));

endmodule

bind sirq_agent sirq_agent_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_oe   (line_oe),
  .line_dout (line_dout),
  .smp_phase (smp_phase),
  .rec_phase (rec_phase),
  .ta_phase  (ta_phase),
  .own_start (own_start),
  .stop_end  (stop_end),
  .mode_quiet(mode_quiet)
);

// File: tb/sirq_agent_tb_top.sv
`timescale 1ns/1ps
module sirq_agent_tb_top;

  localparam int NI = 4;
  localparam int NF = 21;
  localparam int SW = $clog2(NF) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '1;
  logic [NI-1:0] irq_lv = '1;
  logic          host_oe = 1'b0;
  logic          host_v = 1'b1;
  logic          line_oe, line_dout, line;
  int            map_v [NI] = '{1, 5, 20, 30};
  logic [NI*SW-1:0] slot_map;

  int  n_chk = 0;
  int  n_err = 0;
  bit  exp_q[$];
  event rise_ev;

  always #4 clk = ~clk;

  for (genvar j = 0; j < NI; j++) begin : g_map
    assign slot_map[j*SW +: SW] = SW'(map_v[j]);
  end

  assign line = line_oe ? line_dout : (host_oe ? host_v : 1'b1);

  sirq_agent #(.NUM_IRQ(NI), .NUM_FRAMES(NF)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .slot_map (slot_map),
    .line_in  (line),
    .line_oe  (line_oe),
    .line_dout(line_dout)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: expected wire level at each slot's sample clock.
  task automatic push_expect(input int fl_idx, input int fl_at);
    for (int s = 0; s < NF; s++) begin
      bit b = 1'b1;
      for (int j = 0; j < NI; j++) begin
        if (map_v[j] == s) begin
          logic v = irq_lv[j];
          if (j == fl_idx && fl_at <= 3*s + 1) v = ~v;
          if (!v) b = 1'b0;
        end
      end
      exp_q.push_back(b);
    end
  endtask

  // Monitor: pops one item per slot and checks the three phases.
  initial begin
    forever begin
      @(rise_ev);
      @(posedge clk);
      for (int s = 0; s < NF; s++) begin
        bit e = 1'b1;
        if (exp_q.size() == 0) chk(0, "R2", "queue empty", 0, 1);
        else e = exp_q.pop_front();
        @(posedge clk); #2;
        chk(line == e, "R2", $sformatf("slot %0d sample level", s), int'(line), int'(e));
        @(posedge clk); #2;
        chk(line_oe == !e && (e || line_dout), "R3",
            $sformatf("slot %0d recovery oe", s), int'(line_oe), int'(!e));
        @(posedge clk); #2;
        chk(!line_oe, "R4", $sformatf("slot %0d turn-around oe", s), int'(line_oe), 0);
      end
    end
  end

  task automatic flip(input int idx);
    irq_lv[idx] = ~irq_lv[idx];
    irq_in = irq_lv;
  endtask

  task automatic run_cycle(input bit agent_started, input int start_low,
                           input int fl_idx, input int fl_at, input int stop_w);
    if (!agent_started) begin
      @(negedge clk); host_oe = 1'b1; host_v = 1'b0;
    end
    repeat (start_low - 1) @(negedge clk);
    host_v = 1'b1;
    -> rise_ev;
    for (int i = 1; i <= 3*NF + 1; i++) begin
      @(negedge clk);
      if (i == 1) host_oe = 1'b0;
      if (i == fl_at) flip(fl_idx);
    end
    @(negedge clk); host_oe = 1'b1; host_v = 1'b0;
    repeat (stop_w - 1) @(negedge clk);
    @(negedge clk); host_v = 1'b1;
    @(negedge clk); host_oe = 1'b0;
  endtask

  task automatic expect_own_start(input int maxw, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < maxw && !seen; i++) begin
      @(negedge clk);
      if (line_oe && !line_dout) seen = 1'b1;
    end
    chk(seen, req, "self-started low seen", int'(seen), 1);
    host_oe = 1'b1; host_v = 1'b0;
    @(negedge clk);
    chk(!line_oe, req, "self-start lasts one clock", int'(line_oe), 0);
  endtask

  task automatic expect_no_start(input int n, input string req);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (line_oe) bad = 1'b1;
    end
    chk(!bad, req, "wire stays released", int'(bad), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: released during reset
    chk(!line_oe, "R1", "oe in reset", int'(line_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!line_oe, "R1", "oe after reset", int'(line_oe), 0);

    // R8, R1: Continuous after reset, change does not start a cycle
    flip(0);
    expect_no_start(10, "R8");

    // R5, R2: host-opened cycle, stop width 2 selects Quiet (R9)
    push_expect(-1, -1);
    run_cycle(1'b0, 4, -1, -1, 2);
    expect_no_start(10, "R7");

    // R6: Quiet, fresh change opens a cycle; R5 slots in agent-opened cycle
    flip(1);
    expect_own_start(8, "R6");
    push_expect(-1, -1);
    run_cycle(1'b1, 4, -1, -1, 2);

    // R10: out-of-range input ignored
    flip(3);
    expect_no_start(10, "R10");

    // R6: change after slot 1 sampled -> self-start after the stop
    push_expect(0, 10);
    run_cycle(1'b0, 4, 0, 10, 2);
    expect_own_start(8, "R6");

    // R7: change to slot 20 before its sample -> carried, no self-start
    push_expect(2, 10);
    run_cycle(1'b1, 4, 2, 10, 2);
    expect_no_start(10, "R7");

    // R9: width 3 -> Continuous, R8 passive
    push_expect(-1, -1);
    run_cycle(1'b0, 5, -1, -1, 3);
    flip(1);
    expect_no_start(10, "R8");

    // R9: width 5 keeps Continuous
    push_expect(-1, -1);
    run_cycle(1'b0, 4, -1, -1, 5);
    flip(1);
    expect_no_start(10, "R9");

    // R9: back to Quiet; pending change already carried, R7
    push_expect(-1, -1);
    run_cycle(1'b0, 4, -1, -1, 2);
    expect_no_start(10, "R7");

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule